// File: doc/BRIEF.md
# Single-Line I/O Command Engine

This block sits in front of a bank of 32 general-purpose I/O lines, grouped as four ports of eight bits, and lets a controller work on one line at a time. The controller presents a command and a line index with a one-cycle start pulse. The engine then does a single read-modify-write on the output latch of the selected port, or it samples one input line. It answers with a one-cycle done pulse, together with an error flag, a change flag and the sampled level.

For every input line the engine keeps a remembered copy. A test command compares the live input against that copy, reports whether the line has moved since it was last tested, and then refreshes the copy. An initialize command loads every output latch with a fixed pattern chosen by parameter and snapshots all inputs into the remembered copies. An index that falls outside the 32 lines, or a command code that is not defined, raises the error flag and leaves all state untouched.

Top module: `bitio_cmd`

## Requirements
- R1: After reset, out_lines is all zeros, busy, done, err, changed and level are 0, and every remembered input copy is 0.
- R2: A start pulse seen while busy is 0 is accepted. busy is 1 in the following cycle only, and done is 1 in the cycle after that for one cycle only. A start pulse seen while busy is 1 is ignored.
- R3: Line n, for n from 0 to 31, is out_lines[n] and in_lines[n]. Index bits [4:3] select the port, which occupies bits 8p+7..8p, and index bits [2:0] select the bit within that port.
- R4: Command code 1 (set) drives the addressed output line to 1 and leaves all other lines unchanged.
- R5: Command code 2 (clear) drives the addressed output line to 0 and leaves all other lines unchanged.
- R6: Command code 3 (complement) inverts only the addressed output line.
- R7: Command code 0 (initialize) loads out_lines with the INIT_OUT parameter and copies all of in_lines into the remembered copies, whatever the index. It returns err, changed and level as 0.
- R8: An index of 32 or more (any index bit above bit 4 set) with codes 1 to 4 returns err=1, changed=0 and level=0. It changes neither out_lines nor any remembered copy.
- R9: Command code 4 (test) returns level equal to the addressed input. It returns changed=1 exactly when that input differs from its remembered copy, and then stores the input in that copy.
- R10: The first test of a line after reset reports changed=1 if that input reads 1.
- R11: err, changed and level keep their values from one done pulse until the next, and out_lines changes only in a done cycle.
- R12: Command codes 5, 6 and 7 return err=1 and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe |
| cmd | input | 3 | Command code |
| idx | input | 6 | Line index including the out-of-range bit |
| in_lines | input | 32 | Live input line levels |
| out_lines | output | 32 | Output latch contents |
| busy | output | 1 | Command being executed |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last command was rejected |
| changed | output | 1 | Last test saw a change |
| level | output | 1 | Last tested input level |

## Verification
A wrong bit in a port latch shows on out_lines in the done cycle of the command that wrote it. The bench compares the full 32-bit vector after every command, so a write that lands on the wrong bit or port is caught one cycle after busy. A corrupted remembered copy stays hidden until that line is next tested, and then shows as a wrong changed flag. For this reason the sweeps test every line after each change of the input pattern, and they test a line again right after rejected commands to show that the copy was not touched.

// File: rtl/bitio_cmd.sv
module bitio_cmd #(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 8,
  parameter int IDX_W     = 6,
  parameter logic [NUM_PORTS*PORT_W-1:0] INIT_OUT = 32'hA5C3_0F81
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [2:0]                  cmd,
  input  logic [IDX_W-1:0]            idx,
  input  logic [NUM_PORTS*PORT_W-1:0] in_lines,
  output logic [NUM_PORTS*PORT_W-1:0] out_lines,
  output logic                        busy,
  output logic                        done,
  output logic                        err,
  output logic                        changed,
  output logic                        level
);
  localparam int TOTAL  = NUM_PORTS * PORT_W;
  localparam int BIT_W  = $clog2(PORT_W);
  localparam int SEL_W  = $clog2(NUM_PORTS);
  localparam int LINE_W = BIT_W + SEL_W;

  localparam logic [2:0] C_INIT = 3'd0;
  localparam logic [2:0] C_SET  = 3'd1;
  localparam logic [2:0] C_CLR  = 3'd2;
  localparam logic [2:0] C_CPL  = 3'd3;
  localparam logic [2:0] C_TEST = 3'd4;

  logic [2:0]        cmd_q;
  logic [IDX_W-1:0]  idx_q;
  logic              busy_q, done_q, err_q, chg_q, lvl_q;
  logic [TOTAL-1:0]  mem_q;
  logic [PORT_W-1:0] port_q [NUM_PORTS];

  wire [LINE_W-1:0] line    = idx_q[LINE_W-1:0];
  wire [BIT_W-1:0]  bitpos  = idx_q[BIT_W-1:0];
  wire [SEL_W-1:0]  portsel = idx_q[LINE_W-1:BIT_W];
  wire              in_rng  = (idx_q >> LINE_W) == '0;
  wire              bad     = (cmd_q != C_INIT) && (!in_rng || cmd_q > C_TEST);
  wire              do_op   = busy_q && !bad;
  wire [PORT_W-1:0] mask    = {{(PORT_W-1){1'b0}}, 1'b1} << bitpos;
  wire              live    = in_lines[line];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cmd_q  <= '0;
      idx_q  <= '0;
    end else begin
      busy_q <= start && !busy_q;
      done_q <= busy_q;
      if (start && !busy_q) begin
        cmd_q <= cmd;
        idx_q <= idx;
      end
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rst_n)
        port_q[p] <= '0;
      else if (do_op && cmd_q == C_INIT)
        port_q[p] <= INIT_OUT[p*PORT_W +: PORT_W];
      else if (do_op && portsel == SEL_W'(p)) begin
        case (cmd_q)
          C_SET:   port_q[p] <= port_q[p] | mask;
          C_CLR:   port_q[p] <= port_q[p] & ~mask;
          C_CPL:   port_q[p] <= port_q[p] ^ mask;
          default: port_q[p] <= port_q[p];
        endcase
      end
    end
    assign out_lines[p*PORT_W +: PORT_W] = port_q[p];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      mem_q <= '0;
    else if (do_op && cmd_q == C_INIT)
      mem_q <= in_lines;
    else if (do_op && cmd_q == C_TEST)
      mem_q[line] <= live;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      chg_q <= 1'b0;
      lvl_q <= 1'b0;
    end else if (busy_q) begin
      err_q <= bad;
      chg_q <= do_op && cmd_q == C_TEST && (live != mem_q[line]);
      lvl_q <= do_op && cmd_q == C_TEST && live;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign err     = err_q;
  assign changed = chg_q;
  assign level   = lvl_q;
endmodule

// File: rtl/bitio_cmd_sva.sv
module bitio_cmd_sva #(
  parameter int TOTAL = 32,
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [2:0]       cmd,
  input logic [IDX_W-1:0] idx,
  input logic [TOTAL-1:0] out_lines,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic             changed,
  input logic             level
);
  wire [TOTAL-1:0] one = {{(TOTAL-1){1'b0}}, 1'b1};

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_BUSY_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (done && !busy)); // R2
  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R2
  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(out_lines)); // R11
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(err) && $stable(changed) && $stable(level))); // R11
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (out_lines == $past(out_lines))); // R8
  AST_SET_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(cmd, 2) == 3'd1 && $past(idx, 2) < IDX_W'(TOTAL))
      |-> (out_lines == ($past(out_lines) | (one << $past(idx, 2))))); // R4
  AST_CLR_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(cmd, 2) == 3'd2 && $past(idx, 2) < IDX_W'(TOTAL))
      |-> (out_lines == ($past(out_lines) & ~(one << $past(idx, 2))))); // R5
  AST_CPL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(cmd, 2) == 3'd3 && $past(idx, 2) < IDX_W'(TOTAL))
      |-> ((out_lines ^ $past(out_lines)) == (one << $past(idx, 2)))); // R6
  AST_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(cmd, 2) > 3'd4) |-> err); // R12
endmodule

bind bitio_cmd bitio_cmd_sva #(.TOTAL(TOTAL), .IDX_W(IDX_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .idx(idx),
  .out_lines(out_lines), .busy(busy), .done(done), .err(err),
  .changed(changed), .level(level)
);

// File: tb/bitio_cmd_bench.sv
module bitio_cmd_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] INIT_V = 32'hA5C3_0F81;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  cmd = '0;
  logic [5:0]  idx = '0;
  logic [31:0] in_lines = '0;
  logic [31:0] out_lines;
  logic        busy, done, err, changed, level;

  int tests = 0;
  int fails = 0;
  logic [31:0] exp_out = '0;
  logic [31:0] exp_mem = '0;
  logic        exp_err = 1'b0, exp_chg = 1'b0, exp_lvl = 1'b0;

  bitio_cmd #(.INIT_OUT(INIT_V)) u_bitio_cmd (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .idx(idx),
    .in_lines(in_lines), .out_lines(out_lines), .busy(busy), .done(done),
    .err(err), .changed(changed), .level(level)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_results(input string req);
    chk(out_lines == exp_out, req, out_lines, exp_out);
    chk(err == exp_err, req, {31'd0, err}, {31'd0, exp_err});
    chk(changed == exp_chg, req, {31'd0, changed}, {31'd0, exp_chg});
    chk(level == exp_lvl, req, {31'd0, level}, {31'd0, exp_lvl});
  endtask

  task automatic run_cmd(input logic [2:0] c, input logic [5:0] i, input string req, input bit poke = 1'b0);
    @(negedge clk);
    start = 1'b1; cmd = c; idx = i;
    @(negedge clk);
    start = poke; cmd = 3'd1; idx = 6'd0;
    chk(busy && !done, "R2", {30'd0, busy, done}, 32'd2);
    @(negedge clk);
    start = 1'b0;
    chk(done && !busy, "R2", {30'd0, busy, done}, 32'd1);
    exp_err = (c != 3'd0) && (i >= 6'd32 || c > 3'd4);
    exp_chg = 1'b0; exp_lvl = 1'b0;
    if (!exp_err) begin
      case (c)
        3'd0: begin exp_out = INIT_V; exp_mem = in_lines; end
        3'd1: exp_out[i[4:0]] = 1'b1;
        3'd2: exp_out[i[4:0]] = 1'b0;
        3'd3: exp_out[i[4:0]] = ~exp_out[i[4:0]];
        3'd4: begin
          exp_lvl = in_lines[i[4:0]];
          exp_chg = in_lines[i[4:0]] ^ exp_mem[i[4:0]];
          exp_mem[i[4:0]] = in_lines[i[4:0]];
        end
        default: ;
      endcase
    end
    check_results(req);
    if (poke) begin
      @(negedge clk);
      chk(!busy, "R2", {31'd0, busy}, 32'd0);
      chk(out_lines == exp_out, "R2", out_lines, exp_out);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1", {30'd0, busy, done}, 32'd0);
    check_results("R1");

    // R10 / R9: first tests after reset against zeroed copies
    in_lines = 32'hDEAD_BEEF;
    for (int n = 0; n < 32; n++) run_cmd(3'd4, 6'(n), "R10");
    for (int n = 0; n < 32; n += 3) run_cmd(3'd4, 6'(n), "R9");

    // R7: initialize with an arbitrary index
    in_lines = 32'h1234_5678;
    run_cmd(3'd0, 6'd45, "R7");
    for (int n = 0; n < 32; n += 2) run_cmd(3'd4, 6'(n), "R7");

    // R4 / R3: walk set over every line
    for (int n = 0; n < 32; n++) run_cmd(3'd1, 6'(n), "R4");
    // R5: clear every even line
    for (int n = 0; n < 32; n += 2) run_cmd(3'd2, 6'(n), "R5");
    // R6: complement every line
    for (int n = 0; n < 32; n++) run_cmd(3'd3, 6'(n), "R6");
    // R3: port/bit split, one line per port
    for (int p = 0; p < 4; p++) run_cmd(3'd3, 6'(p*8 + 5), "R3");

    // R9: new input pattern, test all lines twice
    in_lines = 32'h0F0F_F0A5;
    for (int n = 0; n < 32; n++) run_cmd(3'd4, 6'(n), "R9");
    for (int n = 0; n < 32; n++) run_cmd(3'd4, 6'(n), "R9");

    // R8: out-of-range indices for every command that takes one
    for (int n = 32; n < 64; n += 5)
      for (int c = 1; c <= 4; c++) run_cmd(3'(c), 6'(n), "R8");
    in_lines[3] = ~in_lines[3];
    run_cmd(3'd4, 6'd35, "R8");
    run_cmd(3'd4, 6'd3, "R8");

    // R12: undefined codes
    for (int c = 5; c < 8; c++) run_cmd(3'(c), 6'd7, "R12");
    in_lines[9] = ~in_lines[9];
    run_cmd(3'd5, 6'd9, "R12");
    run_cmd(3'd4, 6'd9, "R12");

    // R2: start during busy is ignored
    run_cmd(3'd2, 6'd31, "R2", 1'b1);
    run_cmd(3'd3, 6'd16, "R2", 1'b1);

    // R11: results hold between done pulses
    in_lines[20] = ~in_lines[20];
    run_cmd(3'd4, 6'd20, "R11");
    in_lines = ~in_lines;
    repeat (4) @(negedge clk);
    check_results("R11");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule